// File: doc/BRIEF.md
# Parallel Record Distance Array

This block keeps a small bank of unsigned reference records. Beside each record sits its own arithmetic chain, so that one input key is compared against every stored record at the same time. Records are loaded one word at a time through a write port. Each word is gated by a shared load enable and by its own word-select line.

Each word's chain is a ripple-style cascade of identical one-bit slices. The chain works out record-minus-key and key-minus-record together, and the final carry of the first direction picks the non-negative one. This gives the absolute difference. An operation input can switch the same chain to plain subtraction or to addition. A hold input keeps every result at zero. Once hold drops, the results are registered every clock, and a one-cycle done strobe marks the first valid set.

Top module: `recdiff_array`

## Requirements
- R1: On a rising clock edge where `cfg_en` and `wsel[i]` are both high, word i stores `wdata`.
- R2: A word whose `wsel` bit is low, or any word while `cfg_en` is low, keeps its stored value. Records reset to zero.
- R3: During reset, and on the clock edge after any cycle in which `hold` is high, every result field is zero and `done` is low.
- R4: While `hold` is low, each rising edge registers results computed from the key, operation and records present just before that edge. The first valid results therefore appear one clock after `hold` falls.
- R5: `done` is high for exactly one cycle: the cycle after the first edge sampled with `hold` low that follows an edge sampled with `hold` high (reset counts as hold high).
- R6: With `op` = 2'b00, word i's field holds |record − key| in its low DW bits, and its top bit is 0.
- R7: With `op` = 2'b01, the low DW bits hold (record − key) mod 2^DW, and the top bit is 1 exactly when record < key.
- R8: With `op` = 2'b10, the DW+1 bit field holds record + key, with the carry-out in the top bit.
- R9: With `op` = 2'b11, every result field is zero.
- R10: All WORDS results are produced in the same cycle against one key. Word i occupies bits [i*(DW+1) +: DW+1] of `res`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Shared load enable for record writes |
| wsel | input | WORDS | Per-word select for record writes |
| wdata | input | DW | Record value to store |
| key | input | DW | Search key compared with all records |
| hold | input | 1 | High: results forced to zero; low: compute |
| op | input | 2 | 00 abs difference, 01 record−key, 10 record+key, 11 off |
| res | output | WORDS*(DW+1) | Registered per-word results, packed |
| done | output | 1 | One-cycle strobe with first valid results |

## Verification
The hardest cases to reach are the carry extremes of the chains. A borrow or carry has to ripple through every slice, as in 0 against 15 and 15 plus 15, or both subtraction directions have to be zero at once, when the key equals the record. Records are therefore loaded with 0, 15, neighbouring mid values and equal pairs. The keys come from a 32-bit LFSR, with fixed sweeps of 0, 15 and each record value mixed in. Writes with only one of the two enables high are followed by a key of zero in absolute mode, so any stray change shows at the outputs.

// File: rtl/recdiff_pkg.sv
package recdiff_pkg;
  typedef enum logic [1:0] {
    OP_ABS = 2'b00,
    OP_SUB = 2'b01,
    OP_ADD = 2'b10,
    OP_OFF = 2'b11
  } op_e;
endpackage

// File: rtl/recdiff_slice.sv
// One bit of the dual chain: chain A forms x + (y^inv) + carry,
// chain B forms y + ~x + carry (key minus record).
module recdiff_slice (
  input  logic x,
  input  logic y,
  input  logic inv,
  input  logic ca_i,
  input  logic cb_i,
  output logic ca_o,
  output logic cb_o,
  output logic sa,
  output logic sb
);
  logic ya, pa, ga, pb, gb;
  always_comb begin
    ya   = y ^ inv;
    pa   = x ^ ya;
    ga   = x & ya;
    pb   = y ^ ~x;
    gb   = y & ~x;
    ca_o = ga | (pa & ca_i);
    cb_o = gb | (pb & cb_i);
    sa   = pa ^ ca_i;
    sb   = pb ^ cb_i;
  end
endmodule

// File: rtl/recdiff_cell.sv
module recdiff_cell
  import recdiff_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  op_e           op,
  output logic [DW:0]   out
);
  logic [DW:0]   ca, cb;
  logic [DW-1:0] sa, sb;
  logic          inv;

  always_comb begin
    inv   = (op != OP_ADD);
    ca[0] = inv;
    cb[0] = 1'b1;
  end

  for (genvar b = 0; b < DW; b++) begin : g_bit
    recdiff_slice u_slice (
      .x   (x[b]),
      .y   (y[b]),
      .inv (inv),
      .ca_i(ca[b]),
      .cb_i(cb[b]),
      .ca_o(ca[b+1]),
      .cb_o(cb[b+1]),
      .sa  (sa[b]),
      .sb  (sb[b])
    );
  end

  always_comb begin
    unique case (op)
      OP_ABS:  out = {1'b0, (ca[DW] ? sa : sb)};
      OP_SUB:  out = {~ca[DW], sa};
      OP_ADD:  out = {ca[DW], sa};
      default: out = '0;
    endcase
  end
endmodule

// File: rtl/recdiff_array.sv
module recdiff_array
  import recdiff_pkg::*;
#(
  parameter int DW    = 4,
  parameter int WORDS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_en,
  input  logic [WORDS-1:0]         wsel,
  input  logic [DW-1:0]            wdata,
  input  logic [DW-1:0]            key,
  input  logic                     hold,
  input  logic [1:0]               op,
  output logic [WORDS*(DW+1)-1:0]  res,
  output logic                     done
);
  localparam int RW = DW + 1;
  localparam int OW = WORDS * RW;

  logic [DW-1:0] rec_q [WORDS];
  logic [DW-1:0] rec_d [WORDS];
  logic [OW-1:0] cell_res, res_d;
  logic          hold_q, done_d;
  op_e           op_sel;

  always_comb op_sel = op_e'(op);

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_comb rec_d[i] = (cfg_en && wsel[i]) ? wdata : rec_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rec_q[i] <= '0;
      else        rec_q[i] <= rec_d[i];
    end

    recdiff_cell #(.DW(DW)) u_cell (
      .x  (rec_q[i]),
      .y  (key),
      .op (op_sel),
      .out(cell_res[i*RW +: RW])
    );

    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && wsel[i]) |=> rec_q[i] == $past(wdata));
    p_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_en && wsel[i]) |=> $stable(rec_q[i]));
    p_abs_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && op == 2'b00) |=> res[i*RW + DW] == 1'b0);
    p_off_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && op == 2'b11) |=> res[i*RW +: RW] == '0);
  end

  always_comb begin
    res_d  = hold ? '0 : cell_res;
    done_d = hold_q & ~hold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res    <= '0;
      done   <= 1'b0;
      hold_q <= 1'b1;
    end else begin
      res    <= res_d;
      done   <= done_d;
      hold_q <= hold;
    end
  end

  p_hold_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (res == '0 && !done));
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !$past(hold));
endmodule

// File: tb/recdiff_array_tb.sv
module recdiff_array_tb;
  localparam int DW    = 4;
  localparam int WORDS = 8;
  localparam int RW    = DW + 1;
  localparam int OW    = WORDS * RW;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n, cfg_en, hold;
  logic [WORDS-1:0]  wsel;
  logic [DW-1:0]     wdata, key;
  logic [1:0]        op;
  logic [OW-1:0]     res;
  logic              done;

  recdiff_array #(.DW(DW), .WORDS(WORDS)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .wsel(wsel), .wdata(wdata),
    .key(key), .hold(hold), .op(op), .res(res), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [OW-1:0] res;
    logic          done;
    string         tag;
  } exp_t;

  exp_t          q[$];
  logic [DW-1:0] rec_m [WORDS];
  logic          prev_h;
  int            checks = 0;
  int            fails  = 0;
  bit            finished = 0;
  logic [31:0]   lfsr = 32'hACE1_2468;

  function automatic logic [RW-1:0] model(input logic [DW-1:0] r,
                                          input logic [DW-1:0] k,
                                          input logic [1:0] m);
    int ri = int'(r);
    int ki = int'(k);
    int v;
    case (m)
      2'b00: begin v = (ri >= ki) ? ri - ki : ki - ri; return RW'(v); end
      2'b01: begin v = (ri - ki) & ((1 << DW) - 1);
                   return {(ri < ki), DW'(v)}; end
      2'b10: return RW'(ri + ki);
      default: return '0;
    endcase
  endfunction

  task automatic cyc(input logic h, input logic [DW-1:0] k, input logic [1:0] m,
                     input logic we, input logic [WORDS-1:0] sel,
                     input logic [DW-1:0] wd, input string t);
    exp_t e;
    @(negedge clk);
    hold = h; key = k; op = m; cfg_en = we; wsel = sel; wdata = wd;
    for (int i = 0; i < WORDS; i++)
      e.res[i*RW +: RW] = h ? '0 : model(rec_m[i], k, m);
    e.done = prev_h & ~h;
    if (t != "") e.tag = t;
    else if (h) e.tag = "R3";
    else if (prev_h) e.tag = "R4 R10";
    else case (m)
      2'b00: e.tag = "R6 R10";
      2'b01: e.tag = "R7 R10";
      2'b10: e.tag = "R8 R10";
      default: e.tag = "R9";
    endcase
    prev_h = h;
    for (int i = 0; i < WORDS; i++)
      if (we && sel[i]) rec_m[i] = wd;
    @(posedge clk);
    q.push_back(e);
  endtask

  // monitor: compares one expected item per cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      for (int i = 0; i < WORDS; i++) begin
        checks++;
        if (res[i*RW +: RW] !== e.res[i*RW +: RW]) begin
          fails++;
          $display("FAIL %s word %0d: got %h expected %h", e.tag, i,
                   res[i*RW +: RW], e.res[i*RW +: RW]);
        end
      end
      checks++;
      if (done !== e.done) begin
        fails++;
        $display("FAIL R5 done: got %b expected %b", done, e.done);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  localparam logic [DW-1:0] LOADS [WORDS] = '{4'd0, 4'd15, 4'd7, 4'd8,
                                             4'd1, 4'd14, 4'd5, 4'd5};

  initial begin
    for (int i = 0; i < WORDS; i++) rec_m[i] = '0;
    prev_h = 1'b1;
    rst_n = 1'b0; cfg_en = 0; wsel = '0; wdata = '0; key = '0; hold = 1; op = 0;
    #1;
    checks++;
    if (res !== '0 || done !== 1'b0) begin
      fails++;
      $display("FAIL R3 reset: got %h/%b expected 0/0", res, done);
    end
    #(CLK_PERIOD * 2);
    rst_n = 1'b1;

    // R1: load every word while held
    for (int i = 0; i < WORDS; i++)
      cyc(1, 4'd0, 2'b00, 1, WORDS'(1) << i, LOADS[i], "R1 R3");
    // R1 read back: abs against key 0 shows the records
    cyc(0, 4'd0, 2'b00, 0, '0, 4'd0, "R1 R4");
    // R2: select without enable, and enable without select
    cyc(0, 4'd0, 2'b00, 0, '1, 4'd9, "R1");
    cyc(0, 4'd0, 2'b00, 1, '0, 4'd9, "R2");
    cyc(0, 4'd0, 2'b00, 0, '0, 4'd0, "R2");
    // R6 edges: key 0, 15 and each record value
    cyc(0, 4'd15, 2'b00, 0, '0, 4'd0, "");
    for (int k = 0; k < WORDS; k++) cyc(0, LOADS[k], 2'b00, 0, '0, 4'd0, "");
    // R7 and R8 edges
    cyc(0, 4'd15, 2'b01, 0, '0, 4'd0, "");
    cyc(0, 4'd0,  2'b01, 0, '0, 4'd0, "");
    cyc(0, 4'd5,  2'b01, 0, '0, 4'd0, "");
    cyc(0, 4'd15, 2'b10, 0, '0, 4'd0, "");
    cyc(0, 4'd1,  2'b10, 0, '0, 4'd0, "");
    cyc(0, 4'd0,  2'b10, 0, '0, 4'd0, "");
    // R9
    cyc(0, 4'd9, 2'b11, 0, '0, 4'd0, "");
    // R3 / R5: hold again, then release twice
    cyc(1, 4'd3, 2'b00, 0, '0, 4'd0, "");
    cyc(1, 4'd3, 2'b10, 0, '0, 4'd0, "");
    cyc(0, 4'd3, 2'b00, 0, '0, 4'd0, "");
    cyc(0, 4'd4, 2'b00, 0, '0, 4'd0, "");
    cyc(1, 4'd4, 2'b00, 0, '0, 4'd0, "");
    cyc(0, 4'd4, 2'b01, 0, '0, 4'd0, "");
    // R4: LFSR keys, all ops, with write during compute
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cyc(lfsr[9] & lfsr[10] & lfsr[11], lfsr[3:0], lfsr[5:4],
          lfsr[12], WORDS'(lfsr[20:13]), lfsr[24:21], "");
    end
    @(negedge clk);
    #1;
    summary();
  end
endmodule